// File: doc/BRIEF.md
# Double-Buffered Display Word Register

This block holds a 16-bit value for a display. A host writes it one byte at a time. The finished word must still reach the output in a single clock edge. A host store with the select bit low puts the data byte into a staging register for the high half. The visible output does not change. A store with the select bit high joins the staged high byte to the current data byte and commits the whole word to the visible register at once. The display therefore never shows a half-written value.

Clearing is synchronous and works only while the store strobe is high. Because it waits for the clock, a commit followed by a clear still shows the committed word for one full cycle before the output drops to zero. A one-cycle flag marks every cycle in which a new word has just been committed.

An active-low synchronous reset sets every register to zero at power-up. The byte width and the width of the select field are parameters. The shown word is twice the byte width.

Top module: `disp_hold`

## Requirements
- R1: After reset, `shown` is 0 and `shown_valid` is 0. The staged high byte is also 0, which a commit made straight after reset shows as an upper half of 0.
- R2: A cycle with `wr_en`=1, `clr`=0 and `sel` bit 0 equal to 0 loads `din` into the staging register. `shown` does not change on that edge.
- R3: A cycle with `wr_en`=1, `clr`=0 and `sel` bit 0 equal to 1 sets `shown` to {staged byte, `din`} on one clock edge. The staged byte is bits 15:8 and `din` is bits 7:0.
- R4: Only bit 0 of `sel` decides the action. Bits 7:1 have no effect.
- R5: A cycle with `wr_en`=1 and `clr`=1 sets both `shown` and the staging register to zero on the rising edge.
- R6: `clr` has no effect while `wr_en` is 0.
- R7: With `wr_en` at 0, no register changes, whatever `clr`, `sel` or `din` hold.
- R8: When `clr` and a commit request arrive in the same cycle, the clear wins and nothing is committed.
- R9: `shown_valid` is 1 for exactly the cycle after each commit edge. Back-to-back commits hold it high for each of them.
- R10: The clear acts only at a clock edge. A word committed on one edge stays on `shown` until a clear on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Store strobe; enables staging, commit and clear |
| clr | input | 1 | Clear request; acts only when `wr_en` is 1 |
| sel | input | IMM_W (8) | Action select; only bit 0 is used (0 stage, 1 commit) |
| din | input | BYTE_W (8) | Data byte |
| shown | output | 2*BYTE_W (16) | Committed display word |
| shown_valid | output | 1 | One-cycle flag after each commit |

## Verification
The bench builds the block with its default widths: an 8-bit byte, a 16-bit word and an 8-bit select field. With these widths, select values whose upper seven bits are set can be driven against both actions. That checks that only the low bit steers the block. A byte-wide staging register also makes the high and low halves of `shown` easy to tell apart in every expected word. A random tail mixes strobes, clears and select values freely. This reaches clear-versus-commit collisions and commit runs of many cycles.

// File: rtl/disp_hold.sv
module disp_hold #(
  parameter int BYTE_W = 8,
  parameter int IMM_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                clr,
  input  logic [IMM_W-1:0]    sel,
  input  logic [BYTE_W-1:0]   din,
  output logic [2*BYTE_W-1:0] shown,
  output logic                shown_valid
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] stage_q;
  logic [WORD_W-1:0] shown_q;
  logic              valid_q;
  logic              armed_q;

  logic do_clear, do_stage, do_commit;
  logic unused_sel_hi;

  assign do_clear  = wr_en & clr;
  assign do_stage  = wr_en & ~clr & ~sel[0];
  assign do_commit = wr_en & ~clr &  sel[0];
  assign unused_sel_hi = ^sel[IMM_W-1:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      shown_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= do_commit;
      if (do_clear) begin
        stage_q <= '0;
        shown_q <= '0;
      end else if (do_stage) begin
        stage_q <= din;
      end else if (do_commit) begin
        shown_q <= {stage_q, din};
      end
    end
  end

  always_ff @(posedge clk) armed_q <= rst_n;

  assign shown       = shown_q;
  assign shown_valid = valid_q;

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !$past(wr_en)) |-> ($stable(shown) && $stable(stage_q) && !shown_valid));

  p_stage_keeps_shown_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(wr_en && !clr && !sel[0])) |-> ($stable(shown) && stage_q == $past(din)));

  p_commit_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(wr_en && !clr && sel[0])) |-> (shown == {$past(stage_q), $past(din)}));

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(wr_en && clr)) |-> (shown == '0 && stage_q == '0 && !shown_valid));

  p_valid_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && shown_valid) |-> $past(wr_en && !clr && sel[0]));
endmodule

// File: tb/disp_hold_bench.sv
`timescale 1ns/1ps
module disp_hold_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        clr = 1'b0;
  logic [7:0]  sel = '0;
  logic [7:0]  din = '0;
  logic [15:0] shown;
  logic        shown_valid;

  disp_hold u_disp_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .clr(clr),
    .sel(sel), .din(din), .shown(shown), .shown_valid(shown_valid)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [15:0] word;
    logic        vld;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int total = 0;
  int bad = 0;
  logic [7:0]  m_stage = '0;
  logic [15:0] m_shown = '0;
  bit finished = 0;

  task automatic check(input string tag, input logic [15:0] aw, input logic av,
                       input logic [15:0] ew, input logic ev);
    total++;
    if (aw !== ew || av !== ev) begin
      bad++;
      $display("FAIL %s: shown=%h valid=%b expected shown=%h valid=%b", tag, aw, av, ew, ev);
    end
  endtask

  task automatic step(input logic we, input logic cl, input logic [7:0] s,
                      input logic [7:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = we; clr = cl; sel = s; din = d;
    e.vld = 1'b0;
    if (we && cl) begin
      m_stage = '0; m_shown = '0;
    end else if (we && !s[0]) begin
      m_stage = d;
    end else if (we) begin
      m_shown = {m_stage, d};
      e.vld = 1'b1;
    end
    e.word = m_shown;
    e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, shown, shown_valid, e.word, e.vld);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; clr = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset", shown, shown_valid, 16'h0000, 1'b0);
    rst_n = 1'b1;
    m_stage = '0; m_shown = '0;
  endtask

  initial begin
    logic [15:0] lfsr;
    do_reset();
    step(1, 0, 8'h01, 8'h5A, "R1 stage zero after reset");
    step(1, 0, 8'h00, 8'hA5, "R2 stage keeps shown");
    step(1, 0, 8'h01, 8'h3C, "R3 commit word");
    step(0, 0, 8'h00, 8'h00, "R9 pulse ends");
    step(0, 1, 8'h01, 8'hFF, "R6 clear without strobe ignored");
    step(0, 0, 8'hFE, 8'h77, "R7 idle holds");
    step(1, 0, 8'hFE, 8'h12, "R4 upper sel bits ignored on stage");
    step(1, 0, 8'h81, 8'h34, "R4 upper sel bits ignored on commit");
    step(1, 1, 8'h00, 8'h00, "R10 clear lands one edge after commit");
    step(1, 0, 8'h01, 8'h56, "R5 staging cleared");
    step(1, 0, 8'h00, 8'h9C, "R2 restage");
    step(1, 1, 8'h01, 8'hEE, "R8 clear beats commit");
    step(1, 0, 8'h01, 8'h11, "R9 back-to-back commit one");
    step(1, 0, 8'h01, 8'h22, "R9 back-to-back commit two");
    step(1, 0, 8'h00, 8'hC3, "R2 stage again");
    do_reset();
    step(1, 0, 8'h01, 8'h44, "R1 stage cleared by reset");
    lfsr = 16'hACE1;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[1], lfsr[2] & lfsr[3] & lfsr[4], lfsr[15:8], lfsr[11:4],
           "R3 R5 R7 random mix");
    end
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule